// File: doc/BRIEF.md
# Multi-format pixel unpacker with colour table

This block sits between a frame-buffer fetch path and a display output stage. Each cycle it may accept one raw pixel word with a valid flag and a 2-bit format code, and one cycle later it presents the pixel as 24-bit RGB with a valid flag. Three pixel formats are supported. Indexed 8-bit pixels are looked up in a 256-entry colour table. 16-bit pixels are packed 5-6-5 and widened to 8 bits per channel. 32-bit pixels carry RGB in their low three bytes. A fourth code switches the output to black.

The colour table is loaded through a single write port. Each write word carries both the entry index and the colour, so one write updates one entry. Table writes are independent of the pixel stream and may fall in any cycle, including the cycle in which that same entry is being read.

Top module: `pixel_unpacker`

## Requirements
- R1: While rst_n is low at a rising edge, rgb_valid_o is 0 and rgb_o is 0 after that edge, whatever the other inputs are.
- R2: rgb_valid_o after a rising edge equals pix_valid_i sampled at that edge, so every format has a latency of exactly one cycle.
- R3: With format code 1, rgb_o is the colour-table entry addressed by pix_i[7:0]; bits 31:8 of pix_i are ignored.
- R4: A table write with pal_we_i high stores pal_wdata_i[23:16] as red, [15:8] as green and [7:0] as blue into the entry given by pal_wdata_i[31:24]; pixels read in later cycles return the new colour.
- R5: When a table write and a format-1 read of the same entry share a cycle, that pixel shows the colour held before the write.
- R6: With format code 2, red comes from pix_i[15:11], green from pix_i[10:5] and blue from pix_i[4:0]; each field is widened to 8 bits by appending its own top bits below it (5-bit: {f,f[4:2]}, 6-bit: {f,f[5:4]}); pix_i[31:16] is ignored.
- R7: With format code 2, an all-ones field gives 0xFF and an all-zero field gives 0x00 for that channel.
- R8: With format code 3, rgb_o is pix_i[23:0] (red in 23:16, green in 15:8, blue in 7:0); pix_i[31:24] is ignored.
- R9: With format code 0 and valid high, rgb_valid_o is 1 and rgb_o is 0 (black).
- R10: When rgb_valid_o is 0, rgb_o is 0.
- R11: The format code is taken with each pixel, so consecutive pixels of different formats are each decoded in their own format.
- R12: Table writes take effect regardless of pix_valid_i and fmt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_i | input | 2 | Format code: 0 off, 1 indexed, 2 packed 5-6-5, 3 RGB in low bytes |
| pix_i | input | 32 | Raw pixel word |
| pix_valid_i | input | 1 | pix_i and fmt_i hold a pixel this cycle |
| pal_we_i | input | 1 | Colour-table write strobe |
| pal_wdata_i | input | 32 | Table write word: index 31:24, red 23:16, green 15:8, blue 7:0 |
| rgb_o | output | 24 | Output colour: red 23:16, green 15:8, blue 7:0 |
| rgb_valid_o | output | 1 | rgb_o holds a pixel this cycle |

## Verification
The two functions that can coincide are a colour-table write and an indexed read of the very same entry. The bench provokes this by driving a write to an entry already holding a known colour in the same cycle as a format-1 pixel pointing at it; the output of that pixel must show the old colour, and the same pixel repeated one cycle later must show the newly written one. A write issued while the pixel stream carries a disabled-format pixel is judged the same way, by reading the entry back through the indexed path afterwards.

// File: rtl/pxu_pkg.sv
// Package: shared types for the pixel unpacker.
// Assumes 8-bit colour channels and a 2-bit format code.
package pxu_pkg;
    localparam int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;

    typedef enum logic [1:0] {
        FMT_OFF  = 2'd0,
        FMT_PAL  = 2'd1,
        FMT_565  = 2'd2,
        FMT_RGBX = 2'd3
    } pxfmt_e;
endpackage

// File: rtl/pxu_clut.sv
// Colour table: single write port, single synchronous read port.
// Assumes a read and a write to the same entry in one cycle returns the
// stored (old) value; contents are not reset.
module pxu_clut #(
    parameter int DEPTH = 256,
    parameter int COL_W = 24,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [COL_W-1:0] wdata,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] raddr,
    output logic [COL_W-1:0] rdata
);
    logic [COL_W-1:0] mem [DEPTH];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read; sees the array before this edge's write.
    always_ff @(posedge clk) begin
        if (rd_en) rdata <= mem[raddr];
    end
endmodule

// File: rtl/pxu_direct.sv
// Direct-colour decoder: unpacks 5-6-5 and low-byte RGB words to 24-bit
// RGB combinationally. Other format codes give zero.
module pxu_direct
    import pxu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  pxfmt_e             fmt,
    input  logic [WORD_W-1:0]  pix,
    output logic [RGB_W-1:0]   rgb
);
    localparam int R5_W = 5;
    localparam int G6_W = 6;

    logic [R5_W-1:0] r5, b5;
    logic [G6_W-1:0] g6;
    logic [WORD_W-RGB_W-1:0] unused_hi;

    assign r5 = pix[15:11];
    assign g6 = pix[10:5];
    assign b5 = pix[4:0];
    assign unused_hi = pix[WORD_W-1:RGB_W];

    // Select the field layout by format and widen short channels.
    always_comb begin
        unique case (fmt)
            FMT_565:  rgb = {r5, r5[R5_W-1 -: CH_W-R5_W],
                             g6, g6[G6_W-1 -: CH_W-G6_W],
                             b5, b5[R5_W-1 -: CH_W-R5_W]};
            FMT_RGBX: rgb = pix[RGB_W-1:0];
            default:  rgb = '0;
        endcase
    end
endmodule

// File: rtl/pxu_outstage.sv
// Output stage: registers the pixel's valid, format and direct colour,
// then picks the direct colour or the table read data. Both sources
// therefore appear in the same cycle after the input.
module pxu_outstage
    import pxu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  pxfmt_e           in_fmt,
    input  logic [RGB_W-1:0] in_direct,
    input  logic [RGB_W-1:0] pal_rdata,
    output logic [RGB_W-1:0] rgb,
    output logic             rgb_valid
);
    logic             valid_q;
    pxfmt_e           fmt_q;
    logic [RGB_W-1:0] direct_q;

    // Hold the per-pixel controls for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            fmt_q    <= FMT_OFF;
            direct_q <= '0;
        end else begin
            valid_q  <= in_valid;
            fmt_q    <= in_fmt;
            direct_q <= in_direct;
        end
    end

    // Choose the colour source; idle and disabled cycles give black.
    always_comb begin
        if (!valid_q) begin
            rgb = '0;
        end else begin
            unique case (fmt_q)
                FMT_PAL:           rgb = pal_rdata;
                FMT_565, FMT_RGBX: rgb = direct_q;
                default:           rgb = '0;
            endcase
        end
    end

    assign rgb_valid = valid_q;
endmodule

// File: rtl/pixel_unpacker.sv
// Top: multi-format pixel unpacker with a loadable colour table.
// Assumes one pixel per cycle at most and table writes at any time.
module pixel_unpacker
    import pxu_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int PAL_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_i,
    input  logic [WORD_W-1:0] pix_i,
    input  logic              pix_valid_i,
    input  logic              pal_we_i,
    input  logic [WORD_W-1:0] pal_wdata_i,
    output logic [23:0]       rgb_o,
    output logic              rgb_valid_o
);
    localparam int IDX_W = $clog2(PAL_DEPTH);

    pxfmt_e           fmt;
    logic [RGB_W-1:0] direct_rgb;
    logic [RGB_W-1:0] pal_rdata;
    logic             pal_rd;
    logic [WORD_W-RGB_W-IDX_W-1:0] unused_gap;

    assign fmt        = pxfmt_e'(fmt_i);
    assign pal_rd     = pix_valid_i && (fmt == FMT_PAL);
    assign unused_gap = pal_wdata_i[WORD_W-IDX_W-1:RGB_W];

    pxu_clut #(
        .DEPTH (PAL_DEPTH),
        .COL_W (RGB_W)
    ) u_clut (
        .clk   (clk),
        .we    (pal_we_i),
        .waddr (pal_wdata_i[WORD_W-1 -: IDX_W]),
        .wdata (pal_wdata_i[RGB_W-1:0]),
        .rd_en (pal_rd),
        .raddr (pix_i[IDX_W-1:0]),
        .rdata (pal_rdata)
    );

    pxu_direct #(
        .WORD_W (WORD_W)
    ) u_direct (
        .fmt (fmt),
        .pix (pix_i),
        .rgb (direct_rgb)
    );

    pxu_outstage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pix_valid_i),
        .in_fmt    (fmt),
        .in_direct (direct_rgb),
        .pal_rdata (pal_rdata),
        .rgb       (rgb_o),
        .rgb_valid (rgb_valid_o)
    );
endmodule

// File: rtl/pixel_unpacker_chk.sv
// Checker: port-level properties of the pixel unpacker, bound below.
module pixel_unpacker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  fmt_i,
    input logic [31:0] pix_i,
    input logic        pix_valid_i,
    input logic        pal_we_i,
    input logic [31:0] pal_wdata_i,
    input logic [23:0] rgb_o,
    input logic        rgb_valid_o
);
    // R1: reset clears the output on the next cycle.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!rgb_valid_o && rgb_o == 24'h0));

    // R2: valid follows the input valid by one cycle.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rgb_valid_o == $past(pix_valid_i));

    // R6: 5-6-5 field placement.
    p_packed565_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && fmt_i == 2'd2) |=>
            (rgb_o[23:19] == $past(pix_i[15:11]) &&
             rgb_o[15:10] == $past(pix_i[10:5]) &&
             rgb_o[7:3]   == $past(pix_i[4:0])));

    // R8: low three bytes pass straight through.
    p_lowbytes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && fmt_i == 2'd3) |=> rgb_o == $past(pix_i[23:0]));

    // R9: disabled format gives valid black.
    p_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && fmt_i == 2'd0) |=> (rgb_valid_o && rgb_o == 24'h0));

    // R10: idle cycles carry no colour.
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rgb_valid_o |-> rgb_o == 24'h0);
endmodule

bind pixel_unpacker pixel_unpacker_chk u_chk (.*);

// File: tb/pixel_unpacker_bench.sv
module pixel_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_i = 2'd0;
    logic [31:0] pix_i = '0;
    logic        pix_valid_i = 1'b0;
    logic        pal_we_i = 1'b0;
    logic [31:0] pal_wdata_i = '0;
    logic [23:0] rgb_o;
    logic        rgb_valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pixel_unpacker u_pixel_unpacker (.*);

    // Vector: fmt[58:57], valid[56], pix[55:24], expected rgb[23:0]
    localparam int NVEC = 12;
    localparam logic [58:0] VEC [NVEC] = '{
        {2'd3, 1'b1, 32'hAB123456, 24'h123456},
        {2'd2, 1'b1, 32'h0000FFFF, 24'hFFFFFF},
        {2'd3, 1'b1, 32'h00FEDCBA, 24'hFEDCBA},
        {2'd2, 1'b1, 32'hFFFF0000, 24'h000000},
        {2'd2, 1'b1, 32'h0000F800, 24'hFF0000},
        {2'd0, 1'b1, 32'hFFFFFFFF, 24'h000000},
        {2'd2, 1'b1, 32'h000007E0, 24'h00FF00},
        {2'd2, 1'b1, 32'h0000001F, 24'h0000FF},
        {2'd2, 1'b1, 32'h00008410, 24'h848284},
        {2'd3, 1'b0, 32'h12345678, 24'h000000},
        {2'd2, 1'b0, 32'h0000FFFF, 24'h000000},
        {2'd3, 1'b1, 32'hFF000001, 24'h000001}
    };

    task automatic check24(input string tag, input logic [23:0] act,
                           input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s rgb_o actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s rgb_valid_o actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic pal_write(input logic [7:0] idx, input logic [23:0] col);
        pal_we_i    = 1'b1;
        pal_wdata_i = {idx, col};
        @(negedge clk);
        pal_we_i    = 1'b0;
    endtask

    task automatic pixel(input logic [1:0] f, input logic [31:0] p);
        fmt_i = f; pix_i = p; pix_valid_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset dominates a valid pixel on the inputs.
        fmt_i = 2'd3; pix_i = 32'h00FFFFFF; pix_valid_i = 1'b1;
        repeat (3) @(negedge clk);
        check1("R1", rgb_valid_o, 1'b0);
        check24("R1", rgb_o, 24'h0);
        pix_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 valid timing, R6 R7 R8 R9 R10, R11 format per pixel.
        for (int v = 0; v < NVEC; v++) begin
            fmt_i       = VEC[v][58:57];
            pix_valid_i = VEC[v][56];
            pix_i       = VEC[v][55:24];
            @(negedge clk);
            check1("R2", rgb_valid_o, VEC[v][56]);
            if (!VEC[v][56])          check24("R10", rgb_o, VEC[v][23:0]);
            else if (VEC[v][58:57] == 2'd3) check24("R8 R11", rgb_o, VEC[v][23:0]);
            else if (VEC[v][58:57] == 2'd2) check24("R6 R7 R11", rgb_o, VEC[v][23:0]);
            else                      check24("R9 R11", rgb_o, VEC[v][23:0]);
        end
        pix_valid_i = 1'b0;

        // R4: load entries with the stream idle.
        pal_write(8'h00, 24'h0A0B0C);
        pal_write(8'hFF, 24'hC0FFEE);
        pal_write(8'h5A, 24'h102030);

        // R3: index from the low byte, upper bits ignored.
        pixel(2'd1, 32'hFFFFFF00);
        check24("R3", rgb_o, 24'h0A0B0C);
        pixel(2'd1, 32'h000000FF);
        check24("R3 R4", rgb_o, 24'hC0FFEE);
        pixel(2'd1, 32'h1234565A);
        check24("R3 R4", rgb_o, 24'h102030);

        // R5: write and read of entry 0x5A in the same cycle.
        pal_we_i = 1'b1; pal_wdata_i = 32'h5AA0B0C0;
        pixel(2'd1, 32'h0000005A);
        check24("R5", rgb_o, 24'h102030);
        pal_we_i = 1'b0;
        pixel(2'd1, 32'h0000005A);
        check24("R4 R5", rgb_o, 24'hA0B0C0);

        // R12: write during a disabled-format pixel, then read it back.
        pal_we_i = 1'b1; pal_wdata_i = 32'h33445566;
        pixel(2'd0, 32'h00000033);
        check24("R9 R12", rgb_o, 24'h0);
        pal_we_i = 1'b0;
        pixel(2'd1, 32'h00000033);
        check24("R12", rgb_o, 24'h445566);

        // R12: write while a direct-format pixel streams.
        pal_we_i = 1'b1; pal_wdata_i = 32'h01777777;
        pixel(2'd3, 32'h00ABCDEF);
        check24("R8 R12", rgb_o, 24'hABCDEF);
        pal_we_i = 1'b0;
        pixel(2'd1, 32'h00000001);
        check24("R12", rgb_o, 24'h777777);

        // R10: stream stops, output returns to zero.
        pix_valid_i = 1'b0;
        @(negedge clk);
        check1("R10", rgb_valid_o, 1'b0);
        check24("R10", rgb_o, 24'h0);

        // R1: reset mid-stream.
        pix_valid_i = 1'b1; fmt_i = 2'd3; pix_i = 32'h00123456;
        rst_n = 1'b0;
        @(negedge clk);
        check1("R1", rgb_valid_o, 1'b0);
        check24("R1", rgb_o, 24'h0);

        done = 1'b1;
        finish_run();
    end
endmodule